// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt sequencing unit of a small processor core. It tracks three execution modes: normal, maskable service and non-maskable (NMI) service. Each mode owns its own carry/zero flag pair, and the pair shown to the datapath follows the mode. At an instruction boundary the block decides whether to take a pending request. When it takes one, it pushes the return PC onto a hardware stack, switches mode and flag pair, blocks further maskable requests and loads the vector address. It also pulses an acknowledge so that the source's edge latch is cleared. A return-from-interrupt strobe reverses these steps.

The same six-level PC stack also serves ordinary subroutine call and return strobes. Instruction decode and the ALU are outside the block. The core supplies the return PC, flag write data and strobes. It consumes the registered PC load, the flags, the mode, the mask and the stack activity pulses.

Top module: `intr_seq`

## Requirements
- R1: After reset, mode_o is 0 (normal), mask_o is 0, both flags read 0, and pc_load_o, irq_ack_o, nmi_ack_o, stk_push_o and stk_pop_o are all 0.
- R2: When instr_done_i and irq_req_i are high in normal mode with nmi_req_i low, the next cycle shows irq_ack_o=1, stk_push_o=1, pc_load_o=1, pc_o=0xFF6, mode_o=1 and mask_o=1.
- R3: When instr_done_i and nmi_req_i are high outside NMI mode, the next cycle shows nmi_ack_o=1, stk_push_o=1, pc_load_o=1, pc_o=0xFFC and mode_o=2.
- R4: Requests are sampled only while instr_done_i is high; without it, no acknowledge, push or mode change follows.
- R5: A maskable request is not taken while mode_o is not 0. It is taken at a later boundary once normal mode returns, provided it is still asserted.
- R6: An NMI is taken while in maskable service mode (1). An NMI is not taken while already in NMI mode (2).
- R7: When both requests are taken at the same boundary, only the NMI is acknowledged; irq_ack_o stays 0.
- R8: Three flag pairs exist, one per mode. flag_we_i writes flag_c_i/flag_z_i into the pair of the current mode. flag_c_o/flag_z_o show the pair of the current mode, so they change with every mode switch.
- R9: reti_i outside normal mode pops the stack. The next cycle shows stk_pop_o=1, pc_load_o=1 and pc_o equal to the stacked PC. The block leaves NMI mode to the mode that was active when the NMI was taken, and leaves maskable mode to normal. mask_o clears only when normal mode is reached.
- R10: reti_i in normal mode has no effect: no pop, no PC load, and the mode is unchanged.
- R11: The stack holds six entries. A seventh push discards the oldest entry. A pop on an empty stack returns 0.
- R12: call_i pushes pc_i and ret_i pops into pc_o with pc_load_o=1 one cycle later. At a boundary where an interrupt is taken, call_i, ret_i and reti_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_done_i | input | 1 | Instruction boundary strobe |
| irq_req_i | input | 1 | Maskable request (latched edge) |
| nmi_req_i | input | 1 | Non-maskable request (latched edge) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| pc_i | input | PC_W | Return PC to save |
| flag_we_i | input | 1 | Write the current mode's flag pair |
| flag_c_i | input | 1 | Carry write data |
| flag_z_i | input | 1 | Zero write data |
| pc_load_o | output | 1 | Load pc_o into the program counter |
| pc_o | output | PC_W | Vector or popped PC |
| flag_c_o | output | 1 | Carry of the current mode |
| flag_z_o | output | 1 | Zero of the current mode |
| mode_o | output | 2 | 0 normal, 1 maskable service, 2 NMI service |
| mask_o | output | 1 | Maskable requests blocked |
| irq_ack_o | output | 1 | Maskable request taken; clears its latch |
| nmi_ack_o | output | 1 | NMI taken; clears its latch |
| stk_push_o | output | 1 | Stack pushed last cycle |
| stk_pop_o | output | 1 | Stack popped last cycle |

## Verification
Entry is driven with a maskable request alone, an NMI alone, both together, and requests held without a boundary strobe. These cases separate the arbitration order from the boundary gating. A nested sequence (maskable, then NMI, then two returns) tells whether the mode, flag pair and stacked PC unwind in the correct order. A lone NMI from normal mode checks that the NMI return target depends on the mode the NMI interrupted. Seven calls followed by seven returns expose the overwrite and empty-pop behaviour. A call that coincides with an entry shows whether it leaks into the stack.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORM = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_NMI  = 2'd2
  } mode_e;
endpackage

// File: rtl/intr_arb.sv
module intr_arb
  import intr_pkg::*;
(
  input  logic  instr_done_i,
  input  logic  irq_req_i,
  input  logic  nmi_req_i,
  input  mode_e mode_i,
  output logic  take_irq_o,
  output logic  take_nmi_o
);
  // NMI wins; maskable only from normal mode
  always_comb begin
    take_nmi_o = instr_done_i & nmi_req_i & (mode_i != MODE_NMI);
    take_irq_o = instr_done_i & irq_req_i & (mode_i == MODE_NORM) & ~take_nmi_o;
  end
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
  import intr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] sel_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic              c_o,
  output logic              z_o
);
  logic [NUM_MODES-1:0] c_q, z_q;

  for (genvar b = 0; b < NUM_MODES; b++) begin : g_bank
    localparam logic [MODE_W-1:0] BANK_ID = MODE_W'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q[b] <= 1'b0;
        z_q[b] <= 1'b0;
      end else if (we_i && sel_i == BANK_ID) begin
        c_q[b] <= c_i;
        z_q[b] <= z_i;
      end
    end
  end

  always_comb begin
    c_o = 1'b0;
    z_o = 1'b0;
    for (int k = 0; k < NUM_MODES; k++) begin
      if (sel_i == MODE_W'(k)) begin
        c_o = c_q[k];
        z_o = z_q[k];
      end
    end
  end
endmodule

// File: rtl/intr_hw_stack.sv
module intr_hw_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] lvl_q [DEPTH];

  // shift stack: push drops the oldest, pop refills with zero
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] below, above;
    if (i == 0) begin : g_first
      assign below = data_i;
    end else begin : g_mid
      assign below = lvl_q[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign above = '0;
    end else begin : g_up
      assign above = lvl_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lvl_q[i] <= '0;
      else if (push_i) lvl_q[i] <= below;
      else if (pop_i)  lvl_q[i] <= above;
    end
  end

  assign top_o = lvl_q[0];
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_pkg::*;
#(
  parameter int              PC_W      = 12,
  parameter int              STK_DEPTH = 6,
  parameter logic [PC_W-1:0] NMI_VEC   = 12'hFFC,
  parameter logic [PC_W-1:0] IRQ_VEC   = 12'hFF6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_done_i,
  input  logic            irq_req_i,
  input  logic            nmi_req_i,
  input  logic            reti_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            flag_we_i,
  input  logic            flag_c_i,
  input  logic            flag_z_i,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_o,
  output logic            flag_c_o,
  output logic            flag_z_o,
  output logic [1:0]      mode_o,
  output logic            mask_o,
  output logic            irq_ack_o,
  output logic            nmi_ack_o,
  output logic            stk_push_o,
  output logic            stk_pop_o
);
  mode_e           mode_q;
  logic            nmi_from_irq_q;
  logic            take_irq, take_nmi, take_any;
  logic            do_reti, do_call, do_ret, push, pop;
  logic [PC_W-1:0] stk_top;

  intr_arb u_arb (
    .instr_done_i (instr_done_i),
    .irq_req_i    (irq_req_i),
    .nmi_req_i    (nmi_req_i),
    .mode_i       (mode_q),
    .take_irq_o   (take_irq),
    .take_nmi_o   (take_nmi)
  );

  assign take_any = take_irq | take_nmi;
  assign do_reti  = reti_i & (mode_q != MODE_NORM) & ~take_any;
  assign do_call  = call_i & ~take_any;
  assign do_ret   = ret_i & ~take_any & ~do_reti;
  assign push     = take_any | do_call;
  assign pop      = do_reti | do_ret;

  intr_hw_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (pc_i),
    .top_o  (stk_top)
  );

  // flag write lands in the bank of the instruction that just finished
  intr_flag_bank u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .sel_i  (mode_q),
    .c_i    (flag_c_i),
    .z_i    (flag_z_i),
    .c_o    (flag_c_o),
    .z_o    (flag_z_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q         <= MODE_NORM;
      nmi_from_irq_q <= 1'b0;
    end else if (take_nmi) begin
      mode_q         <= MODE_NMI;
      nmi_from_irq_q <= (mode_q == MODE_IRQ);
    end else if (take_irq) begin
      mode_q         <= MODE_IRQ;
    end else if (do_reti) begin
      if (mode_q == MODE_NMI && nmi_from_irq_q) mode_q <= MODE_IRQ;
      else                                      mode_q <= MODE_NORM;
      nmi_from_irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_load_o  <= 1'b0;
      pc_o       <= '0;
      irq_ack_o  <= 1'b0;
      nmi_ack_o  <= 1'b0;
      stk_push_o <= 1'b0;
      stk_pop_o  <= 1'b0;
    end else begin
      pc_load_o  <= take_any | pop;
      irq_ack_o  <= take_irq;
      nmi_ack_o  <= take_nmi;
      stk_push_o <= push;
      stk_pop_o  <= pop;
      if (take_nmi)      pc_o <= NMI_VEC;
      else if (take_irq) pc_o <= IRQ_VEC;
      else if (pop)      pc_o <= stk_top;
    end
  end

  assign mode_o = mode_q;
  assign mask_o = (mode_q != MODE_NORM);
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int              PC_W    = 12,
  parameter logic [PC_W-1:0] NMI_VEC = 12'hFFC
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_done_i,
  input logic            irq_req_i,
  input logic            nmi_req_i,
  input logic            reti_i,
  input logic            ret_i,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_o,
  input logic [1:0]      mode_o,
  input logic            mask_o,
  input logic            irq_ack_o,
  input logic            nmi_ack_o,
  input logic            stk_push_o,
  input logic            stk_pop_o
);
  p_no_irq_in_service_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o |=> !irq_ack_o);

  p_nmi_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && nmi_req_i && irq_req_i && !mask_o) |=> (nmi_ack_o && !irq_ack_o));

  p_entry_pushes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o || nmi_ack_o) |-> (pc_load_o && stk_push_o));

  p_nmi_vector_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ack_o |-> (pc_o == NMI_VEC && mode_o == 2'd2));

  p_boundary_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_done_i |=> (!irq_ack_o && !nmi_ack_o));

  p_reti_normal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ret_i && mode_o == 2'd0) |=> (!stk_pop_o && mode_o == 2'd0));

  p_ack_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_ack_o, nmi_ack_o}));

  p_no_nmi_nest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !reti_i) |=> !nmi_ack_o);
endmodule

bind intr_seq intr_seq_chk #(.PC_W(PC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_done_i (instr_done_i),
  .irq_req_i    (irq_req_i),
  .nmi_req_i    (nmi_req_i),
  .reti_i       (reti_i),
  .ret_i        (ret_i),
  .pc_load_o    (pc_load_o),
  .pc_o         (pc_o),
  .mode_o       (mode_o),
  .mask_o       (mask_o),
  .irq_ack_o    (irq_ack_o),
  .nmi_ack_o    (nmi_ack_o),
  .stk_push_o   (stk_push_o),
  .stk_pop_o    (stk_pop_o)
);

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_done = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
  logic            reti = 1'b0, call = 1'b0, ret = 1'b0;
  logic [PC_W-1:0] pc_in = '0;
  logic            flag_we = 1'b0, flag_c = 1'b0, flag_z = 1'b0;
  logic            pc_load, fc, fz, mask, irq_ack, nmi_ack, spush, spop;
  logic [PC_W-1:0] pc_out;
  logic [1:0]      mode;

  int n_chk = 0;
  int n_fail = 0;

  intr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_done_i(instr_done), .irq_req_i(irq_req),
    .nmi_req_i(nmi_req), .reti_i(reti), .call_i(call), .ret_i(ret), .pc_i(pc_in),
    .flag_we_i(flag_we), .flag_c_i(flag_c), .flag_z_i(flag_z),
    .pc_load_o(pc_load), .pc_o(pc_out), .flag_c_o(fc), .flag_z_o(fz),
    .mode_o(mode), .mask_o(mask), .irq_ack_o(irq_ack), .nmi_ack_o(nmi_ack),
    .stk_push_o(spush), .stk_pop_o(spop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, then release; outputs are checked at the following negedge
  task automatic step(input logic d, input logic ir, input logic nm, input logic rt,
                      input logic cl, input logic rs, input logic [PC_W-1:0] p,
                      input logic we, input logic c, input logic z);
    instr_done = d; irq_req = ir; nmi_req = nm; reti = rt; call = cl; ret = rs;
    pc_in = p; flag_we = we; flag_c = c; flag_z = z;
    @(negedge clk);
    instr_done = 0; irq_req = 0; nmi_req = 0; reti = 0; call = 0; ret = 0;
    flag_we = 0; flag_c = 0; flag_z = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0); chk("R1 mask", mask, 0);
    chk("R1 flags", {fc, fz}, 0); chk("R1 pulses", {pc_load, irq_ack, nmi_ack, spush, spop}, 0);
  endtask

  task automatic t_no_boundary();
    step(0, 1, 1, 0, 0, 0, 12'h050, 0, 0, 0);
    chk("R4 acks", {irq_ack, nmi_ack, spush}, 0);
    chk("R4 mode", mode, 0);
  endtask

  task automatic t_nested();
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R8 normal flags", {fc, fz}, 2'b10);
    step(1, 1, 0, 0, 0, 0, 12'h123, 0, 0, 0);
    chk("R2 ack/push/load", {irq_ack, spush, pc_load}, 3'b111);
    chk("R2 vector", pc_out, 12'hFF6);
    chk("R2 mode/mask", {mode, mask}, 3'b011);
    chk("R8 irq bank", {fc, fz}, 2'b00);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R8 irq write", {fc, fz}, 2'b01);
    step(1, 1, 0, 0, 0, 0, 12'h155, 0, 0, 0);
    chk("R5 blocked", {irq_ack, spush, mode}, {2'b00, 2'd1});
    step(1, 0, 1, 0, 0, 0, 12'h200, 0, 0, 0);
    chk("R6 preempt", {nmi_ack, spush, mode}, {2'b11, 2'd2});
    chk("R3 vector", pc_out, 12'hFFC);
    chk("R8 nmi bank", {fc, fz}, 2'b00);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(1, 0, 1, 0, 0, 0, 12'h222, 0, 0, 0);
    chk("R6 no nest", {nmi_ack, spush, mode}, {2'b00, 2'd2});
    chk("R8 nmi write", {fc, fz}, 2'b11);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 pop/load", {spop, pc_load}, 2'b11);
    chk("R9 pc", pc_out, 12'h200);
    chk("R9 back to irq", {mode, mask}, 3'b011);
    chk("R8 irq restored", {fc, fz}, 2'b01);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 pc", pc_out, 12'h123);
    chk("R9 back to normal", {mode, mask}, 3'b000);
    chk("R8 normal restored", {fc, fz}, 2'b10);
  endtask

  task automatic t_reti_normal();
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R10 no effect", {spop, pc_load, mode}, 4'b0000);
  endtask

  task automatic t_simultaneous();
    step(1, 1, 1, 0, 0, 0, 12'h300, 0, 0, 0);
    chk("R7 nmi only", {nmi_ack, irq_ack}, 2'b10);
    chk("R3 mode", mode, 2);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 nmi from normal", {mode, mask}, 3'b000);
    chk("R9 pc", pc_out, 12'h300);
    step(1, 1, 0, 0, 0, 0, 12'h310, 0, 0, 0);
    chk("R5 pending taken", {irq_ack, mode}, {1'b1, 2'd1});
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 pc", pc_out, 12'h310);
  endtask

  task automatic t_stack();
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1, 0, PC_W'(12'h010 + i), 0, 0, 0);
    chk("R12 push pulse", spush, 1);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      chk("R12 ret load", pc_load, 1);
      chk("R11 lifo", pc_out, 32'h016 - i);
    end
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11 empty pop", pc_out, 0);
  endtask

  task automatic t_call_on_entry();
    step(1, 1, 0, 0, 1, 0, 12'h400, 0, 0, 0);
    chk("R12 entry wins", {irq_ack, mode}, {1'b1, 2'd1});
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 pc", pc_out, 12'h400);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R12 call ignored", pc_out, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_boundary();
    t_nested();
    t_reti_normal();
    t_simultaneous();
    t_stack();
    t_call_on_entry();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule